// File: doc/BRIEF.md
# Rational Resize Phase Sequencer

This block walks a reduced scale ratio and produces the list of per-phase entries that a resize coefficient table needs. The ratio is given as `num/denom`, where `num` is the output span length and `denom` is the input span length, both already in lowest terms. After a one-cycle `start` pulse the block emits exactly `num` entries. Each entry carries a 10-bit phase weight on a 512 scale and a count of how many source pixels to step past before the next phase.

The walk depends on the ratio. A shrinking ratio (`denom > num`) uses an error accumulator that starts at `denom` and is folded modulo `2*num`. A ratio with `denom == 1` replicates pixels and forces nearest-neighbour weights. Every other growing ratio uses a simple accumulator that starts at zero and gains `denom` for each phase.

Divisions and the modulo are done by one shared multi-cycle restoring divider, and the sequencer waits between entries while it runs. Each entry comes with the selected mode, a shrink flag and the sharpness setting in force, so a tap generator further down the pipeline can apply its own rules.

Top module: `rsz_phase_seq`

## Requirements
- R1: A `start` pulse with `num` equal to 0, `num` above 31 or `denom` equal to 0 sets `cfg_err` in the following cycle. It produces no entries, and `busy` stays low. The next accepted `start` clears `cfg_err`.
- R2: The mode is chosen at `start` as follows. `denom > num` gives shrink, encoded `ent_mode = 2'b01`. Otherwise `denom == 1` gives integer grow, encoded `2'b10`. All other cases give fractional grow, encoded `2'b11`. Every entry of a run carries this encoding.
- R3: An accepted run emits exactly `num` entries, each marked by a single-cycle `ent_valid`. `ent_last` is high on the final entry only. `busy` is low from the cycle of that final entry onward.
- R4: In fractional grow, with an accumulator `a` that starts at 0, each entry's weight is `512 - floor(512*a/num)`. After the weight is taken, `denom` is added to `a`.
- R5: In fractional grow, the advance is 1 when the updated `a` is at least `num`, and then `num` is taken off `a`. Otherwise the advance is 0.
- R6: In integer grow, every entry has weight 512 and `ent_sharp = 0`. The advance is 1 on the last entry and 0 on all others.
- R7: In shrink, the accumulator `a` starts at `denom`. For each entry, `a` first becomes `num + (a - num) mod 2*num`. The weight is then `512 - floor(512*(a - num)/(2*num))`, and after that `2*denom` is added to `a`.
- R8: In shrink, the advance is `floor((a - num)/(2*num))`, computed on `a` after the `2*denom` addition.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The run in progress finishes with its original ratio and entry count.
- R10: In both shrink and fractional grow, `ent_sharp` repeats the `sharp` value captured at `start`. `ent_down` is high only for shrink entries.
- R11: After reset, `ent_valid`, `busy` and `cfg_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run with the ratio on `num`/`denom` |
| num | input | 8 | Output length of the reduced ratio |
| denom | input | 8 | Input length of the reduced ratio |
| sharp | input | 6 | Sharpness setting passed along with the entries |
| busy | output | 1 | Run in progress |
| cfg_err | output | 1 | Last `start` carried an unusable ratio |
| ent_valid | output | 1 | Entry strobe |
| ent_weight | output | 10 | Phase weight, 512 = all of the current pixel |
| ent_adv | output | 9 | Source pixels to advance after this phase |
| ent_mode | output | 2 | Mode code of the run |
| ent_down | output | 1 | Entry belongs to a shrink run |
| ent_sharp | output | 6 | Sharpness for this entry |
| ent_last | output | 1 | Final entry of the run |

## Verification
The hardest situation to reach is the shrink walk deep into a long run. There, the modulo fold and the multi-pixel advance both work on an accumulator that has gone through many additions of `2*denom`. The stimulus reaches it with extreme ratios such as 31/255 and 5/17, and compares every emitted entry against a model built from the requirement formulas. A second hard case is a `start` that lands in the middle of a run. The bench reaches it by pulsing `start` with a different ratio one cycle after a run has been accepted, then checking that the entry count and values still follow the first ratio.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
  typedef enum logic [1:0] {
    RSZ_NONE = 2'b00,
    RSZ_DOWN = 2'b01,
    RSZ_INT  = 2'b10,
    RSZ_FRAC = 2'b11
  } rsz_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MOD_GO,
    ST_MOD_WAIT,
    ST_WT_GO,
    ST_WT_WAIT,
    ST_ADV_GO,
    ST_ADV_WAIT,
    ST_EMIT
  } rsz_state_e;
endpackage

// File: rtl/rsz_divider.sv
module rsz_divider #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  dsr_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    rem_sh;
  logic [W:0]    rem_sub;
  logic          fits;

  always_comb begin
    rem_sh  = {rem_q[W-1:0], quo_q[W-1]};
    fits    = rem_sh >= {1'b0, dsr_q};
    rem_sub = rem_sh - {1'b0, dsr_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quo_q <= dividend;
        dsr_q <= divisor;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        rem_q <= fits ? rem_sub : rem_sh;
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) done <= 1'b1;
      end
    end
  end

  assign quo = quo_q;
  assign rem = rem_q[W-1:0];
endmodule

// File: rtl/rsz_mode_sel.sv
module rsz_mode_sel
  import rsz_pkg::*;
#(
  parameter int NUM_IN_W = 8,
  parameter int DEN_W    = 8,
  parameter int MAX_ENT  = 31
) (
  input  logic [NUM_IN_W-1:0] num,
  input  logic [DEN_W-1:0]    denom,
  output rsz_mode_e           mode,
  output logic                bad
);
  localparam int CMP_W = (NUM_IN_W > DEN_W) ? NUM_IN_W : DEN_W;

  logic [CMP_W-1:0] n_x;
  logic [CMP_W-1:0] d_x;

  always_comb begin
    n_x = CMP_W'(num);
    d_x = CMP_W'(denom);
    bad = (n_x == '0) || (d_x == '0) || (n_x > CMP_W'(MAX_ENT));
    if (d_x > n_x)               mode = RSZ_DOWN;
    else if (d_x == CMP_W'(1))   mode = RSZ_INT;
    else                         mode = RSZ_FRAC;
  end
endmodule

// File: rtl/rsz_phase_seq.sv
module rsz_phase_seq
  import rsz_pkg::*;
#(
  parameter int NUM_IN_W = 8,
  parameter int DEN_W    = 8,
  parameter int SHARP_W  = 6,
  parameter int MAX_ENT  = 31,
  parameter int WT_FRAC  = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [NUM_IN_W-1:0] num,
  input  logic [DEN_W-1:0]    denom,
  input  logic [SHARP_W-1:0]  sharp,
  output logic                busy,
  output logic                cfg_err,
  output logic                ent_valid,
  output logic [WT_FRAC:0]    ent_weight,
  output logic [DEN_W:0]      ent_adv,
  output logic [1:0]          ent_mode,
  output logic                ent_down,
  output logic [SHARP_W-1:0]  ent_sharp,
  output logic                ent_last
);
  localparam int NUM_W  = $clog2(MAX_ENT + 1);
  localparam int WT_W   = WT_FRAC + 1;
  localparam int ADV_W  = DEN_W + 1;
  localparam int ACC_W  = ((DEN_W > NUM_W) ? DEN_W : NUM_W) + 3;
  localparam int DIV_W  = ACC_W + WT_FRAC + 1;
  localparam logic [WT_W-1:0] ONE = WT_W'(1) << WT_FRAC;

  rsz_state_e          state_q;
  rsz_mode_e           mode_q;
  rsz_mode_e           mode_in;
  logic                bad_in;
  logic [NUM_W-1:0]    num_q;
  logic [DEN_W-1:0]    den_q;
  logic [SHARP_W-1:0]  sharp_q;
  logic [NUM_W-1:0]    idx_q;
  logic [ACC_W-1:0]    acc_q;
  logic [WT_W-1:0]     wt_q;
  logic [ADV_W-1:0]    adv_q;

  logic [ACC_W-1:0]    num_x;
  logic [ACC_W-1:0]    den_x;
  logic [ACC_W-1:0]    two_num;
  logic [ACC_W-1:0]    grow_sum;
  logic                is_last;

  logic                div_go;
  logic                div_done;
  logic [DIV_W-1:0]    div_a;
  logic [DIV_W-1:0]    div_b;
  logic [DIV_W-1:0]    div_quo;
  logic [DIV_W-1:0]    div_rem;
  logic [DIV_W-1:0]    rem_plus;

  rsz_mode_sel #(
    .NUM_IN_W(NUM_IN_W),
    .DEN_W   (DEN_W),
    .MAX_ENT (MAX_ENT)
  ) u_mode_sel (
    .num  (num),
    .denom(denom),
    .mode (mode_in),
    .bad  (bad_in)
  );

  rsz_divider #(
    .W(DIV_W)
  ) u_div (
    .clk     (clk),
    .rst     (rst),
    .go      (div_go),
    .dividend(div_a),
    .divisor (div_b),
    .done    (div_done),
    .quo     (div_quo),
    .rem     (div_rem)
  );

  always_comb begin
    num_x    = ACC_W'(num_q);
    den_x    = ACC_W'(den_q);
    two_num  = num_x << 1;
    grow_sum = acc_q + den_x;
    is_last  = (idx_q == num_q - 1'b1);
    rem_plus = DIV_W'(num_x) + div_rem;
  end

  // Divider operand selection per walk step
  always_comb begin
    div_go = 1'b0;
    div_a  = '0;
    div_b  = DIV_W'(1);
    case (state_q)
      ST_MOD_GO: begin
        div_go = 1'b1;
        div_a  = DIV_W'(acc_q - num_x);
        div_b  = DIV_W'(two_num);
      end
      ST_WT_GO: begin
        div_go = 1'b1;
        if (mode_q == RSZ_DOWN) begin
          div_a = DIV_W'(acc_q - num_x) << WT_FRAC;
          div_b = DIV_W'(two_num);
        end else begin
          div_a = DIV_W'(acc_q) << WT_FRAC;
          div_b = DIV_W'(num_x);
        end
      end
      ST_ADV_GO: begin
        div_go = 1'b1;
        div_a  = DIV_W'(acc_q - num_x);
        div_b  = DIV_W'(two_num);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      mode_q     <= RSZ_NONE;
      num_q      <= '0;
      den_q      <= '0;
      sharp_q    <= '0;
      idx_q      <= '0;
      acc_q      <= '0;
      wt_q       <= '0;
      adv_q      <= '0;
      cfg_err    <= 1'b0;
      ent_valid  <= 1'b0;
      ent_weight <= '0;
      ent_adv    <= '0;
      ent_mode   <= 2'b00;
      ent_down   <= 1'b0;
      ent_sharp  <= '0;
      ent_last   <= 1'b0;
    end else begin
      ent_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (bad_in) begin
              cfg_err <= 1'b1;
            end else begin
              cfg_err <= 1'b0;
              mode_q  <= mode_in;
              num_q   <= NUM_W'(num);
              den_q   <= denom;
              sharp_q <= sharp;
              idx_q   <= '0;
              wt_q    <= ONE;
              adv_q   <= '0;
              case (mode_in)
                RSZ_DOWN: begin
                  acc_q   <= ACC_W'(denom);
                  state_q <= ST_MOD_GO;
                end
                RSZ_INT: begin
                  acc_q   <= '0;
                  state_q <= ST_EMIT;
                end
                default: begin
                  acc_q   <= '0;
                  state_q <= ST_WT_GO;
                end
              endcase
            end
          end
        end
        ST_MOD_GO:  state_q <= ST_MOD_WAIT;
        ST_MOD_WAIT: begin
          if (div_done) begin
            acc_q   <= ACC_W'(rem_plus);
            state_q <= ST_WT_GO;
          end
        end
        ST_WT_GO:   state_q <= ST_WT_WAIT;
        ST_WT_WAIT: begin
          if (div_done) begin
            wt_q <= ONE - WT_W'(div_quo);
            if (mode_q == RSZ_DOWN) begin
              acc_q   <= acc_q + (den_x << 1);
              state_q <= ST_ADV_GO;
            end else begin
              if (grow_sum >= num_x) begin
                acc_q <= grow_sum - num_x;
                adv_q <= ADV_W'(1);
              end else begin
                acc_q <= grow_sum;
                adv_q <= '0;
              end
              state_q <= ST_EMIT;
            end
          end
        end
        ST_ADV_GO:  state_q <= ST_ADV_WAIT;
        ST_ADV_WAIT: begin
          if (div_done) begin
            adv_q   <= ADV_W'(div_quo);
            state_q <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          ent_valid <= 1'b1;
          ent_mode  <= mode_q;
          ent_down  <= (mode_q == RSZ_DOWN);
          ent_last  <= is_last;
          if (mode_q == RSZ_INT) begin
            ent_weight <= ONE;
            ent_adv    <= ADV_W'(is_last);
            ent_sharp  <= '0;
          end else begin
            ent_weight <= wt_q;
            ent_adv    <= adv_q;
            ent_sharp  <= sharp_q;
          end
          idx_q <= idx_q + 1'b1;
          if (is_last)                 state_q <= ST_IDLE;
          else if (mode_q == RSZ_DOWN) state_q <= ST_MOD_GO;
          else if (mode_q == RSZ_INT)  state_q <= ST_EMIT;
          else                         state_q <= ST_WT_GO;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/rsz_phase_seq_chk.sv
module rsz_phase_seq_chk #(
  parameter int NUM_IN_W = 8,
  parameter int DEN_W    = 8,
  parameter int SHARP_W  = 6,
  parameter int WT_FRAC  = 9
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic [NUM_IN_W-1:0] num,
  input logic                busy,
  input logic                cfg_err,
  input logic                ent_valid,
  input logic [WT_FRAC:0]    ent_weight,
  input logic [DEN_W:0]      ent_adv,
  input logic [1:0]          ent_mode,
  input logic                ent_down,
  input logic [SHARP_W-1:0]  ent_sharp,
  input logic                ent_last
);
  logic [NUM_IN_W-1:0] num_lat;
  logic [NUM_IN_W-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      num_lat <= '0;
      seen_q  <= '0;
    end else if (start && !busy) begin
      num_lat <= num;
      seen_q  <= '0;
    end else if (ent_valid) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  // R1
  err_silent_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !ent_valid && !busy);
  // R2
  mode_coded_chk: assert property (@(posedge clk) disable iff (rst)
    ent_valid |-> ent_mode != 2'b00);
  // R3
  last_count_chk: assert property (@(posedge clk) disable iff (rst)
    ent_valid && ent_last |-> (seen_q + 1'b1) == num_lat);
  // R3
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ent_valid && ent_last);
  // R4
  weight_range_chk: assert property (@(posedge clk) disable iff (rst)
    ent_valid |-> ent_weight <= ((WT_FRAC+1)'(1) << WT_FRAC) && ent_weight != '0);
  // R5
  grow_adv_chk: assert property (@(posedge clk) disable iff (rst)
    ent_valid && ent_mode == 2'b11 |-> ent_adv <= (DEN_W+1)'(1));
  // R6
  int_entry_chk: assert property (@(posedge clk) disable iff (rst)
    ent_valid && ent_mode == 2'b10 |->
      ent_weight == ((WT_FRAC+1)'(1) << WT_FRAC) && ent_sharp == '0 &&
      ent_adv == (DEN_W+1)'(ent_last));
  // R10
  down_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ent_valid |-> ent_down == (ent_mode == 2'b01));
endmodule

bind rsz_phase_seq rsz_phase_seq_chk #(
  .NUM_IN_W(NUM_IN_W),
  .DEN_W   (DEN_W),
  .SHARP_W (SHARP_W),
  .WT_FRAC (WT_FRAC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .num       (num),
  .busy      (busy),
  .cfg_err   (cfg_err),
  .ent_valid (ent_valid),
  .ent_weight(ent_weight),
  .ent_adv   (ent_adv),
  .ent_mode  (ent_mode),
  .ent_down  (ent_down),
  .ent_sharp (ent_sharp),
  .ent_last  (ent_last)
);

// File: tb/rsz_phase_seq_bench.sv
`timescale 1ns/1ps
module rsz_phase_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] num = '0;
  logic [7:0] denom = '0;
  logic [5:0] sharp = '0;
  logic       busy, cfg_err, ent_valid, ent_down, ent_last;
  logic [9:0] ent_weight;
  logic [8:0] ent_adv;
  logic [1:0] ent_mode;
  logic [5:0] ent_sharp;

  int checks = 0;
  int failures = 0;
  int exp_w [0:31];
  int exp_a [0:31];

  always #4 clk = ~clk;

  rsz_phase_seq u_rsz_phase_seq (
    .clk(clk), .rst(rst), .start(start), .num(num), .denom(denom),
    .sharp(sharp), .busy(busy), .cfg_err(cfg_err), .ent_valid(ent_valid),
    .ent_weight(ent_weight), .ent_adv(ent_adv), .ent_mode(ent_mode),
    .ent_down(ent_down), .ent_sharp(ent_sharp), .ent_last(ent_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mode_of(int n, int d);
    if (d > n) return 1;
    if (d == 1) return 2;
    return 3;
  endfunction

  // Model from the requirement formulas (R4, R5, R6, R7, R8)
  task automatic build_ref(input int n, input int d);
    int a;
    int m;
    m = mode_of(n, d);
    a = (m == 1) ? d : 0;
    for (int i = 0; i < n; i++) begin
      if (m == 2) begin
        exp_w[i] = 512;
        exp_a[i] = (i == n - 1) ? 1 : 0;
      end else if (m == 3) begin
        exp_w[i] = 512 - (512 * a) / n;
        a = a + d;
        exp_a[i] = (a >= n) ? 1 : 0;
        if (a >= n) a = a - n;
      end else begin
        a = n + (a - n) % (2 * n);
        exp_w[i] = 512 - (512 * (a - n)) / (2 * n);
        a = a + 2 * d;
        exp_a[i] = (a - n) / (2 * n);
      end
    end
  endtask

  task automatic pulse_start(input int n, input int d, input int sh);
    @(negedge clk);
    start = 1'b1;
    num   = 8'(n);
    denom = 8'(d);
    sharp = 6'(sh);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Collects one run and compares every entry to the model
  task automatic collect(input int n, input int d, input int sh, input bit poke);
    int got;
    int m;
    int guard;
    m = mode_of(n, d);
    got = 0;
    guard = 0;
    build_ref(n, d);
    if (poke) begin
      start = 1'b1;
      num   = 8'd5;
      denom = 8'd1;
      @(negedge clk);
      start = 1'b0;
    end
    while (got < n && guard < 20000) begin
      if (ent_valid) begin
        check(ent_weight == 10'(exp_w[got]), m == 1 ? "R7 weight" : (m == 2 ? "R6 weight" : "R4 weight"),
              int'(ent_weight), exp_w[got]);
        check(ent_adv == 9'(exp_a[got]), m == 1 ? "R8 advance" : (m == 2 ? "R6 advance" : "R5 advance"),
              int'(ent_adv), exp_a[got]);
        check(ent_mode == 2'(m), "R2 mode", int'(ent_mode), m);
        check(ent_down == (m == 1), "R10 down flag", int'(ent_down), int'(m == 1));
        check(ent_sharp == 6'((m == 2) ? 0 : sh), "R10 sharp", int'(ent_sharp), (m == 2) ? 0 : sh);
        check(ent_last == (got == n - 1), "R3 last", int'(ent_last), int'(got == n - 1));
        if (got == n - 1) check(!busy, "R3 busy low at last", int'(busy), 0);
        got++;
      end
      if (got < n) begin
        @(negedge clk);
        guard++;
      end
    end
    check(got == n, poke ? "R9 entry count" : "R3 entry count", got, n);
    got = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (ent_valid) got++;
    end
    check(got == 0, poke ? "R9 no extra entries" : "R3 no extra entries", got, 0);
    check(!busy, "R3 idle after run", int'(busy), 0);
  endtask

  task automatic run_case(input int n, input int d, input int sh);
    pulse_start(n, d, sh);
    collect(n, d, sh, 1'b0);
    check(!cfg_err, "R1 err clear on good start", int'(cfg_err), 0);
  endtask

  task automatic run_poke(input int n, input int d, input int sh);
    pulse_start(n, d, sh);
    collect(n, d, sh, 1'b1);
  endtask

  task automatic run_bad(input int n, input int d);
    int seen;
    pulse_start(n, d, 3);
    check(cfg_err, "R1 err set", int'(cfg_err), 1);
    check(!busy, "R1 busy stays low", int'(busy), 0);
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (ent_valid || busy) seen++;
    end
    check(seen == 0, "R1 no entries", seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!ent_valid, "R11 valid low", int'(ent_valid), 0);
    check(!busy, "R11 busy low", int'(busy), 0);
    check(!cfg_err, "R11 err low", int'(cfg_err), 0);

    run_case(3, 1, 8);     // R6 integer grow
    run_case(1, 1, 8);     // R6 single entry
    run_case(3, 2, 8);     // R4 R5 fractional grow
    run_case(31, 30, 12);  // R4 R5 largest table
    run_case(2, 3, 8);     // R7 R8 shrink
    run_case(1, 2, 5);     // R7 R8 halving
    run_case(5, 17, 20);   // R7 R8 multi-pixel advance
    run_case(31, 255, 32); // R7 R8 extreme shrink
    run_bad(32, 5);        // R1 too many entries
    run_case(4, 3, 1);     // R1 cleared by next good start
    run_bad(0, 3);         // R1 zero output length
    run_bad(4, 0);         // R1 zero input length
    run_poke(3, 2, 7);     // R9 start ignored while busy
    run_poke(2, 3, 7);     // R9 start ignored during shrink

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule